// File: doc/BRIEF.md
# Digital Soft-Start Sequencer

This block brings a two-phase step-down converter controller up from rest in a fixed, repeatable way. When both supply-good flags are true and no inhibit is requested, it latches the target set by the 5-bit voltage-identification (VID) code. It then ramps a 12-bit reference word from zero to that target over a fixed number of clock cycles. The default is 2048 cycles.

As the reference climbs, the block releases the power stage and the protection comparators in stages. Before a ramp starts, the low-side switches are forced on once the driver supply is above 2 V, which drains the output capacitor. High-side switching is allowed only once the reference reaches the 1 V level, which is the bottom of the PWM triangle. The negative-current-limit and undervoltage comparators are released at the 0.8 V level. Power-good is raised when the ramp ends.

A supply loss or an inhibit request sends the block back to its resting state. When the condition clears, a new ramp starts from zero. The reference word uses a scale of 0.5 mV per step, so 1 V reads as 2000 and 1.850 V reads as 3700.

Top module: `softstart_seq`

## Requirements
- R1: After reset, `ref_o` is 0, and `ls_force_o`, `hs_en_o`, `ncl_uv_en_o` and `pgood_o` are all low.
- R2: The target in reference steps is 3700 - 50*min(code, 30), where the code is `vid_i` read as an unsigned number. Code 0 gives 1.850 V (3700). Codes 30 and 31 both give 1.100 V (2200).
- R3: A ramp starts on the clock edge at which `logic_ok_i` and `drv_ok_i` are high and `inhibit_i` is low. After that edge `ref_o` is 0. Once k more edges of the ramp have passed, `ref_o` equals floor(target*k / 2^RAMP_LOG2). It equals the target exactly 2^RAMP_LOG2 edges after the start.
- R4: The VID code is sampled only at the start edge. Later changes to `vid_i` do not alter the ramp or the final reference until the next start.
- R5: `ls_force_o` is high only while the block is at rest, `drv_2v_i` is high and `inhibit_i` is low. It reflects those inputs one edge later.
- R6: `hs_en_o` is high exactly when a ramp is running or complete and `ref_o` >= HS_TH (default 2000, 1 V).
- R7: `ncl_uv_en_o` is high exactly when a ramp is running or complete and `ref_o` >= CMP_TH (default 1600, 0.8 V).
- R8: `pgood_o` goes high on the edge at which `ref_o` reaches the target. It stays high while the supplies stay good and inhibit stays low.
- R9: If either supply flag drops during a ramp or after it, the next edge returns the block to rest. At that edge `ref_o` becomes 0, `pgood_o` goes low, and both enables go low.
- R10: While `inhibit_i` is high, `ls_force_o` and `hs_en_o` are low from the next edge on. Once `inhibit_i` is released with the supplies good, a fresh ramp starts from 0.
- R11: While a ramp continues, `ref_o` never decreases from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| logic_ok_i | input | 1 | Logic supply above its turn-on threshold |
| drv_ok_i | input | 1 | Driver supply above its turn-on threshold |
| drv_2v_i | input | 1 | Driver supply above 2 V |
| inhibit_i | input | 1 | Inhibit request; stops all switching |
| vid_i | input | VID_W | Voltage-identification code |
| ref_o | output | REF_W | Reference word, 0.5 mV per step |
| ls_force_o | output | 1 | Force low-side switches on |
| hs_en_o | output | 1 | Allow high-side switching |
| ncl_uv_en_o | output | 1 | Enable negative-current-limit and undervoltage comparators |
| pgood_o | output | 1 | Power good |

## Verification
The bench builds two copies of the block.

The main copy sets RAMP_LOG2 to 6, so each ramp lasts 64 cycles. With this setting, randomly timed supply drops, inhibit pulses and VID changes can interrupt ramps at every stage and also let many ramps finish. The same setting makes it cheap to sweep all 32 VID codes to their final value.

A second copy keeps the default 2048-cycle ramp and runs one full ramp to 1.100 V. This checks the exact cycles where the 0.8 V and 1 V thresholds are crossed (1490 and 1862) and the final step that raises power-good.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        SS_REST = 2'd0,
        SS_RAMP = 2'd1,
        SS_DONE = 2'd2
    } ss_phase_e;

endpackage

// File: rtl/ss_vid_decode.sv
module ss_vid_decode #(
    parameter int VID_W     = 5,
    parameter int REF_W     = 12,
    parameter int TOP_LSB   = 3700,
    parameter int STEP_LSB  = 50,
    parameter int LAST_CODE = 30
) (
    input  logic [VID_W-1:0] code_i,
    output logic [REF_W-1:0] target_o
);

    logic [VID_W-1:0] idx;

    always_comb begin
        idx      = (code_i > VID_W'(LAST_CODE)) ? VID_W'(LAST_CODE) : code_i;
        target_o = REF_W'(TOP_LSB) - REF_W'(STEP_LSB) * REF_W'(idx);
    end

    // R2: the decoded target never leaves the programmed window
    always_comb begin
        a_r2_target_window: assert (target_o <= REF_W'(TOP_LSB) &&
                                    target_o >= REF_W'(TOP_LSB - STEP_LSB * LAST_CODE));
    end

endmodule

// File: rtl/ss_ramp_scale.sv
module ss_ramp_scale #(
    parameter int REF_W = 12,
    parameter int CNT_W = 12,
    parameter int SHIFT = 11
) (
    input  logic [REF_W-1:0] target_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [REF_W-1:0] ref_o
);

    localparam int PROD_W = REF_W + CNT_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod  = PROD_W'(target_i) * PROD_W'(count_i);
        ref_o = REF_W'(prod >> SHIFT);
    end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_pkg::*;
#(
    parameter int VID_W     = 5,
    parameter int REF_W     = 12,
    parameter int RAMP_LOG2 = 11,
    parameter int HS_TH     = 2000,
    parameter int CMP_TH    = 1600,
    parameter int TOP_LSB   = 3700,
    parameter int STEP_LSB  = 50,
    parameter int LAST_CODE = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             logic_ok_i,
    input  logic             drv_ok_i,
    input  logic             drv_2v_i,
    input  logic             inhibit_i,
    input  logic [VID_W-1:0] vid_i,
    output logic [REF_W-1:0] ref_o,
    output logic             ls_force_o,
    output logic             hs_en_o,
    output logic             ncl_uv_en_o,
    output logic             pgood_o
);

    localparam int             CNT_W   = RAMP_LOG2 + 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(1) << RAMP_LOG2;

    typedef struct packed {
        ss_phase_e        phase;
        logic [CNT_W-1:0] cnt;
        logic [REF_W-1:0] tgt;
        logic             ls;
    } seq_s;

    seq_s             seq_d, seq_q;
    logic [REF_W-1:0] vid_target;
    logic             run_ok;
    logic             active;

    ss_vid_decode #(
        .VID_W    (VID_W),
        .REF_W    (REF_W),
        .TOP_LSB  (TOP_LSB),
        .STEP_LSB (STEP_LSB),
        .LAST_CODE(LAST_CODE)
    ) u_vid (
        .code_i  (vid_i),
        .target_o(vid_target)
    );

    ss_ramp_scale #(
        .REF_W(REF_W),
        .CNT_W(CNT_W),
        .SHIFT(RAMP_LOG2)
    ) u_scale (
        .target_i(seq_q.tgt),
        .count_i (seq_q.cnt),
        .ref_o   (ref_o)
    );

    // next-state computation
    always_comb begin
        run_ok = logic_ok_i && drv_ok_i && !inhibit_i;
        seq_d  = seq_q;
        unique case (seq_q.phase)
            SS_REST: begin
                if (run_ok) begin
                    seq_d.phase = SS_RAMP;
                    seq_d.cnt   = '0;
                    seq_d.tgt   = vid_target;
                end
            end
            SS_RAMP: begin
                if (!run_ok) begin
                    seq_d.phase = SS_REST;
                    seq_d.cnt   = '0;
                    seq_d.tgt   = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CNT_W'(1);
                    if (seq_d.cnt == CNT_END) begin
                        seq_d.phase = SS_DONE;
                    end
                end
            end
            SS_DONE: begin
                if (!run_ok) begin
                    seq_d.phase = SS_REST;
                    seq_d.cnt   = '0;
                    seq_d.tgt   = '0;
                end
            end
            default: begin
                seq_d.phase = SS_REST;
                seq_d.cnt   = '0;
                seq_d.tgt   = '0;
            end
        endcase
        seq_d.ls = (seq_d.phase == SS_REST) && drv_2v_i && !inhibit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.phase <= SS_REST;
            seq_q.cnt   <= '0;
            seq_q.tgt   <= '0;
            seq_q.ls    <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        active      = (seq_q.phase != SS_REST);
        ls_force_o  = seq_q.ls;
        hs_en_o     = active && (ref_o >= REF_W'(HS_TH));
        ncl_uv_en_o = active && (ref_o >= REF_W'(CMP_TH));
        pgood_o     = (seq_q.phase == SS_DONE);
    end

    // R3: a start edge leaves a running ramp at reference zero
    a_r3_start_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == SS_REST && run_ok) |=> (ref_o == '0 && seq_q.phase == SS_RAMP));

    // R6: high side never switches below its threshold
    a_r6_hs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en_o |-> (ref_o >= REF_W'(HS_TH)));

    // R8: power good only with the reference at the latched target
    a_r8_pgood_at_target: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> (ref_o == seq_q.tgt));

    // R9: supply loss while active returns everything to rest
    a_r9_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !(logic_ok_i && drv_ok_i)) |=>
            (ref_o == '0 && !pgood_o && !hs_en_o && !ncl_uv_en_o));

    // R10: inhibit turns every power switch off
    a_r10_inhibit_off: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> (!ls_force_o && !hs_en_o));

    // R11: reference never falls during a continuing ramp
    a_r11_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == SS_RAMP && run_ok) |=> (ref_o >= $past(ref_o)));

    // R5: forced low side and high-side switching never overlap
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        ls_force_o |-> !hs_en_o);

endmodule

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;

    localparam int L0 = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lg_ok = 1'b0, dv_ok = 1'b0, d2v = 1'b0, inh = 1'b0;
    logic [4:0]  vid = 5'd0;
    logic [11:0] ref0;
    logic        ls0, hs0, cmp0, pg0;

    logic        b_lg = 1'b0, b_dv = 1'b0, b_2v = 1'b0, b_inh = 1'b0;
    logic [4:0]  b_vid = 5'd30;
    logic [11:0] ref1;
    logic        ls1, hs1, cmp1, pg1;

    int nchk = 0;
    int nfail = 0;

    int m_phase = 0;
    int m_cnt = 0;
    int m_tgt = 0;
    int m_ls = 0;

    always #5 clk = ~clk;

    softstart_seq #(.RAMP_LOG2(L0)) u0 (
        .clk(clk), .rst_n(rst_n), .logic_ok_i(lg_ok), .drv_ok_i(dv_ok),
        .drv_2v_i(d2v), .inhibit_i(inh), .vid_i(vid), .ref_o(ref0),
        .ls_force_o(ls0), .hs_en_o(hs0), .ncl_uv_en_o(cmp0), .pgood_o(pg0)
    );

    softstart_seq u1 (
        .clk(clk), .rst_n(rst_n), .logic_ok_i(b_lg), .drv_ok_i(b_dv),
        .drv_2v_i(b_2v), .inhibit_i(b_inh), .vid_i(b_vid), .ref_o(ref1),
        .ls_force_o(ls1), .hs_en_o(hs1), .ncl_uv_en_o(cmp1), .pgood_o(pg1)
    );

    function automatic int tgt_f(int code);
        return 3700 - 50 * ((code > 30) ? 30 : code);
    endfunction

    function automatic int ref_f(int tgt, int cnt, int sh);
        return (tgt * cnt) >> sh;
    endfunction

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_step();
        int run;
        run = (lg_ok && dv_ok && !inh) ? 1 : 0;
        case (m_phase)
            0: if (run == 1) begin m_phase = 1; m_cnt = 0; m_tgt = tgt_f(int'(vid)); end
            1: if (run == 0) begin m_phase = 0; m_cnt = 0; m_tgt = 0; end
               else begin m_cnt++; if (m_cnt == (1 << L0)) m_phase = 2; end
            default: if (run == 0) begin m_phase = 0; m_cnt = 0; m_tgt = 0; end
        endcase
        m_ls = (m_phase == 0 && d2v && !inh) ? 1 : 0;
    endtask

    task automatic compare_all();
        int r;
        r = (m_phase == 0) ? 0 : ref_f(m_tgt, m_cnt, L0);
        check("R3 ref", int'(ref0), r);
        check("R5 ls_force", int'(ls0), m_ls);
        check("R6 hs_en", int'(hs0), (m_phase != 0 && r >= 2000) ? 1 : 0);
        check("R7 ncl_uv_en", int'(cmp0), (m_phase != 0 && r >= 1600) ? 1 : 0);
        check("R8 pgood", int'(pg0), (m_phase == 2) ? 1 : 0);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog R3 actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ref", int'(ref0), 0);
        check("R1 ls", int'(ls0), 0);
        check("R1 hs", int'(hs0), 0);
        check("R1 cmp", int'(cmp0), 0);
        check("R1 pgood", int'(pg0), 0);
        check("R1 u1 pgood", int'(pg1), 0);

        // full default-length ramp on u1 to 1.100 V
        b_2v = 1'b1;
        @(negedge clk);
        check("R5 u1 ls before ramp", int'(ls1), 1);
        b_lg = 1'b1; b_dv = 1'b1;
        for (int k = 0; k <= 2048; k++) begin
            @(negedge clk);
            if (k == 0) b_vid = 5'd0;  // R4 change after start is ignored
            check("R3 u1 ref", int'(ref1), ref_f(2200, k, 11));
            check("R6 u1 hs", int'(hs1), (k >= 1862) ? 1 : 0);
            check("R7 u1 cmp", int'(cmp1), (k >= 1490) ? 1 : 0);
            check("R8 u1 pgood", int'(pg1), (k == 2048) ? 1 : 0);
            check("R5 u1 ls", int'(ls1), 0);
        end
        check("R4 u1 final ref", int'(ref1), 2200);
        b_dv = 1'b0;
        @(negedge clk);
        check("R9 u1 ref cleared", int'(ref1), 0);
        check("R9 u1 pgood cleared", int'(pg1), 0);

        // sweep every VID code on u0
        d2v = 1'b1;
        for (int c = 0; c < 32; c++) begin
            vid = 5'(c);
            lg_ok = 1'b1; dv_ok = 1'b1;
            for (int k = 0; k <= (1 << L0); k++) begin
                cyc();
                if (k == 5) vid = 5'(31 - c);
            end
            check("R2 final ref", int'(ref0), tgt_f(c));
            check("R4 vid held", int'(ref0), tgt_f(c));
            check("R8 pgood at end", int'(pg0), 1);
            lg_ok = 1'b0;
            cyc();
            check("R9 ref after drop", int'(ref0), 0);
            check("R9 pgood after drop", int'(pg0), 0);
        end

        // inhibit mid-ramp and restart
        vid = 5'd0; lg_ok = 1'b1; dv_ok = 1'b1;
        repeat (50) cyc();
        inh = 1'b1;
        cyc();
        check("R10 hs off", int'(hs0), 0);
        check("R10 ls off", int'(ls0), 0);
        repeat (4) cyc();
        check("R10 ls held off", int'(ls0), 0);
        inh = 1'b0;
        cyc();
        check("R10 restart ref", int'(ref0), 0);
        repeat (10) cyc();
        check("R10 restart ramp", int'(ref0), ref_f(3700, 10, L0));

        // random phase
        for (int n = 0; n < 12000; n++) begin
            lg_ok = (($urandom % 300) != 0);
            dv_ok = (($urandom % 300) != 0);
            inh   = (($urandom % 400) == 0);
            d2v   = (($urandom % 4) != 0);
            if (($urandom % 20) == 0) vid = 5'($urandom % 32);
            cyc();
        end
        finish_run();
    end

endmodule